// File: doc/BRIEF.md
# PWM Timer with Blanked Cycle-by-Cycle Clear

An up-counting PWM timer with several compare channels. Each channel compares the shared counter with its own compare value and makes a reference level, either "active below compare" or "active at or above compare". That level then goes through a polarity bit and an enable gate to reach its pin. One designated channel, the cleared channel, can be forced inactive by an external comparator-style input. Once that clear takes hold, it stays in force until the next update event. This gives per-cycle current limiting in a power stage.

A second channel serves as the blanking source. While its raw reference is active, the comparator input is ignored. This hides switching noise at the start of each cycle. A typical setup uses a period of 1700, main compares of 850, and a blanking compare of 25.

The counter can be started by a pulse, or restarted by a rising edge on an external trigger. It can run freely or stop after one period. The period value is double-buffered, so a new period takes effect only at the next update.

Top module: `pwm_blank_timer`

## Requirements
- R1: After reset the counter is 0 and `update_o` is low. Once running, the counter steps by one each clock from 0 up to the active period P. On the next clock it wraps to 0 and `update_o` is high for exactly one cycle, so updates are P+1 cycles apart.
- R2: The active period resets to `DEF_PERIOD` (1700). A value on `period_i` is copied into it only on a clock that produces an update.
- R3: Compare behaviour, with channel index g and `cmp_val_i[g*CW +: CW]` as channel g's compare value:
  - Reference when `mode_i[g]`=0: high while counter < compare.
  - Reference when `mode_i[g]`=1: high while counter >= compare.
  - An enabled pin drives the reference XOR `pol_i[g]`.
- R4: A channel with `chan_en_i[g]`=0 drives 0 on `ch_o[g]`.
- R5: The clear works as follows:
  - A clock edge where `cmp_in_i` is high and blanking is inactive sets a clear flag.
  - From the next cycle the reference of channel `CLR_CH` (default 1) is 0, and its enabled pin equals its polarity bit.
  - The flag holds until an update.
- R6: Blanking is the raw reference of channel `BLANK_CH` (default 2), taken before its polarity and enable. While blanking is active, `cmp_in_i` has no effect.
- R7: If an update and a qualified clear fall on the same clock edge, the update wins and the flag ends up clear.
- R8: With `one_pulse_i`=1, the counter stops at 0 after the update that ends a period. It stays there until restarted.
- R9: With `slave_en_i`=1, a rising edge of `trig_i` resets the counter to 0 and starts it. This produces no update pulse and leaves the clear flag as it was. If it coincides with the end of a period, the trigger wins.
- R10: While stopped, the counter holds. A one-cycle `start_i` pulse starts counting from the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse for the counter |
| trig_i | input | 1 | External trigger; rising edge restarts the counter when enabled |
| slave_en_i | input | 1 | Enables trigger reset-and-start |
| one_pulse_i | input | 1 | Stop after the update that ends a period |
| cmp_in_i | input | 1 | Comparator-style clear request |
| period_i | input | CW | Period value, loaded at update |
| cmp_val_i | input | NCH*CW | Compare values, channel g at bits g*CW +: CW |
| mode_i | input | NCH | Per-channel mode: 0 active below compare, 1 active at/above |
| pol_i | input | NCH | Per-channel output polarity (1 inverts) |
| chan_en_i | input | NCH | Per-channel output enable |
| ch_o | output | NCH | Channel pins |
| update_o | output | 1 | One-cycle update pulse |

## Verification
Two events can land on one clock edge: the end-of-period update and a qualified clear request. The trigger restart can also coincide with the end of a period. The bench provokes the first by raising the comparator input exactly when the counter sits at the period value, outside blanking. It judges the result at the pin in the next cycle, where the cleared channel must show its normal PWM level. Around these directed cases, a bench-side arithmetic model sweeps compare values, modes, polarities, enables and a pseudo-random comparator pattern. The pins and update pulse are compared with that model every cycle.

// File: rtl/pbt_pkg.sv
// Shared types for the PWM timer with blanked clear.
// Assumes: compare reference modes are a single bit per channel.
package pbt_pkg;
    typedef enum logic {
        PWM_BELOW = 1'b0,   // reference high while counter < compare
        PWM_ABOVE = 1'b1    // reference high while counter >= compare
    } pwm_mode_e;
endpackage

// File: rtl/pbt_counter.sv
// Time base: up-counter 0..P with a preloaded period, update pulse,
// start pulse, one-pulse stop and trigger reset-and-start.
// Assumes: trig_i is synchronous to clk; start_i is ignored while running.
module pbt_counter #(
    parameter int unsigned CW         = 16,
    parameter int unsigned DEF_PERIOD = 1700
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          trig_i,
    input  logic          slave_en_i,
    input  logic          one_pulse_i,
    input  logic [CW-1:0] period_i,
    output logic [CW-1:0] cnt_o,
    output logic          ovf_o,
    output logic          update_o
);
    localparam logic [CW-1:0] ONE     = CW'(1);
    localparam logic [CW-1:0] PER_RST = CW'(DEF_PERIOD);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] per_q;
    logic          run_q;
    logic          trig_q;
    logic          trig_edge;

    // Rising edge of the trigger, only when trigger mode is enabled
    assign trig_edge = slave_en_i & trig_i & ~trig_q;
    // End of period; a coincident trigger restart suppresses it
    assign ovf_o     = run_q & (cnt_q == per_q) & ~trig_edge;
    assign cnt_o     = cnt_q;

    // Counter, shadow period, run flag and update pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            per_q    <= PER_RST;
            run_q    <= 1'b0;
            trig_q   <= 1'b0;
            update_o <= 1'b0;
        end else begin
            trig_q   <= trig_i;
            update_o <= ovf_o;
            if (trig_edge || ovf_o) begin
                cnt_q <= '0;
            end else if (run_q) begin
                cnt_q <= cnt_q + ONE;
            end
            if (ovf_o) begin
                per_q <= period_i;
            end
            if (trig_edge || start_i) begin
                run_q <= 1'b1;
            end else if (ovf_o && one_pulse_i) begin
                run_q <= 1'b0;
            end
        end
    end

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= per_q);
    // R1
    upd_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |-> (cnt_q == '0));
    // R2
    per_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_o |=> $stable(per_q));
    // R8
    one_pulse_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && one_pulse_i && !start_i) |=> (!run_q && cnt_q == '0));
    // R9
    trig_no_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_edge |=> (cnt_q == '0 && !update_o && run_q));
endmodule

// File: rtl/pbt_compare.sv
// One compare unit: raw reference level from counter, compare value and mode.
// Assumes: purely combinational; polarity, enable and clear are applied above.
module pbt_compare
    import pbt_pkg::*;
#(
    parameter int unsigned CW = 16
) (
    input  logic [CW-1:0] cnt_i,
    input  logic [CW-1:0] cmp_i,
    input  pwm_mode_e     mode_i,
    output logic          ref_o
);
    // Select the comparison sense by mode
    always_comb begin
        unique case (mode_i)
            PWM_BELOW: ref_o = (cnt_i < cmp_i);
            PWM_ABOVE: ref_o = (cnt_i >= cmp_i);
            default:   ref_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/pbt_clear_latch.sv
// Clear flag: set by a comparator request outside blanking, cleared by update.
// Assumes: ovf_i marks the clock edge that raises the update pulse.
module pbt_clear_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_i,
    input  logic blank_i,
    input  logic ovf_i,
    output logic flag_o
);
    logic flag_q;
    logic qual;

    // Comparator request with blanking applied
    assign qual   = cmp_i & ~blank_i;
    assign flag_o = flag_q;

    // Flag register: update has priority over a new request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (ovf_i) begin
            flag_q <= 1'b0;
        end else if (qual) begin
            flag_q <= 1'b1;
        end
    end

    // R7
    upd_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_i |=> !flag_q);
    // R5
    clr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_i && !blank_i && !ovf_i) |=> flag_q);
    // R6
    blank_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && (blank_i || !cmp_i)) |=> !flag_q);
endmodule

// File: rtl/pwm_blank_timer.sv
// PWM timer top: shared counter, NCH compare channels, blanked clear on
// channel CLR_CH with blanking taken from channel BLANK_CH.
// Assumes: CLR_CH != BLANK_CH; pins are combinational from registered state.
module pwm_blank_timer
    import pbt_pkg::*;
#(
    parameter int unsigned CW         = 16,
    parameter int unsigned NCH        = 4,
    parameter int unsigned DEF_PERIOD = 1700,
    parameter int unsigned CLR_CH     = 1,
    parameter int unsigned BLANK_CH   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              trig_i,
    input  logic              slave_en_i,
    input  logic              one_pulse_i,
    input  logic              cmp_in_i,
    input  logic [CW-1:0]     period_i,
    input  logic [NCH*CW-1:0] cmp_val_i,
    input  logic [NCH-1:0]    mode_i,
    input  logic [NCH-1:0]    pol_i,
    input  logic [NCH-1:0]    chan_en_i,
    output logic [NCH-1:0]    ch_o,
    output logic              update_o
);
    logic [CW-1:0]  cnt;
    logic           ovf;
    logic           clr_flag;
    logic [NCH-1:0] ref_raw;
    logic [NCH-1:0] ref_fin;

    pbt_counter #(.CW(CW), .DEF_PERIOD(DEF_PERIOD)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .trig_i     (trig_i),
        .slave_en_i (slave_en_i),
        .one_pulse_i(one_pulse_i),
        .period_i   (period_i),
        .cnt_o      (cnt),
        .ovf_o      (ovf),
        .update_o   (update_o)
    );

    pbt_clear_latch u_clr (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmp_i  (cmp_in_i),
        .blank_i(ref_raw[BLANK_CH]),
        .ovf_i  (ovf),
        .flag_o (clr_flag)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pbt_compare #(.CW(CW)) u_cmp (
            .cnt_i (cnt),
            .cmp_i (cmp_val_i[g*CW +: CW]),
            .mode_i(pwm_mode_e'(mode_i[g])),
            .ref_o (ref_raw[g])
        );
        if (g == CLR_CH) begin : g_clr
            // Cleared channel: reference forced low while the flag is set
            assign ref_fin[g] = ref_raw[g] & ~clr_flag;
        end else begin : g_plain
            // Ordinary channel: reference passes through
            assign ref_fin[g] = ref_raw[g];
        end
        // Pin: polarity then enable gate
        assign ch_o[g] = chan_en_i[g] & (ref_fin[g] ^ pol_i[g]);
    end

    // R5
    clr_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flag && chan_en_i[CLR_CH]) |-> (ch_o[CLR_CH] == pol_i[CLR_CH]));
    // R1
    upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |=> !update_o);
endmodule

// File: tb/sim_pwm_blank_timer.sv
`timescale 1ns/1ps
module sim_pwm_blank_timer;
    localparam int CW = 16;
    localparam int NCH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 0, trig_i = 0, slave_en_i = 0, one_pulse_i = 0, cmp_in_i = 0;
    logic [CW-1:0] period_i = 16'd1700;
    logic [CW-1:0] cv [NCH];
    logic [NCH-1:0] mode_i = '0, pol_i = '0, chan_en_i = '0;
    logic [NCH-1:0] ch_o;
    logic update_o;
    logic [NCH*CW-1:0] cmp_val_i;

    assign cmp_val_i = {cv[3], cv[2], cv[1], cv[0]};

    always #10 clk = ~clk;   // 50 MHz

    pwm_blank_timer u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .trig_i(trig_i),
        .slave_en_i(slave_en_i), .one_pulse_i(one_pulse_i), .cmp_in_i(cmp_in_i),
        .period_i(period_i), .cmp_val_i(cmp_val_i), .mode_i(mode_i),
        .pol_i(pol_i), .chan_en_i(chan_en_i), .ch_o(ch_o), .update_o(update_o)
    );

    int nchk = 0, nerr = 0, cyc = 0;
    bit chk_on = 0;

    // Bench model of the requirements
    logic [CW-1:0] m_cnt, m_per;
    bit m_run, m_flag, m_upd, m_trq;
    bit tedge, tovf, tblank;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= 0; m_per <= 16'd1700; m_run <= 0; m_flag <= 0; m_upd <= 0; m_trq <= 0;
        end else begin
            tedge  = slave_en_i && trig_i && !m_trq;
            tovf   = m_run && (m_cnt == m_per) && !tedge;
            tblank = mode_i[2] ? (m_cnt >= cv[2]) : (m_cnt < cv[2]);
            m_trq <= trig_i;
            m_upd <= tovf;
            if (tedge || tovf) m_cnt <= 0;
            else if (m_run) m_cnt <= m_cnt + 16'd1;
            if (tovf) m_per <= period_i;
            if (tedge || start_i) m_run <= 1;
            else if (tovf && one_pulse_i) m_run <= 0;
            if (tovf) m_flag <= 0;
            else if (cmp_in_i && !tblank) m_flag <= 1;
        end
    end

    function automatic bit exp_pin(int g);
        bit r;
        r = mode_i[g] ? (m_cnt >= cv[g]) : (m_cnt < cv[g]);
        if (g == 1 && m_flag) r = 0;
        return chan_en_i[g] & (r ^ pol_i[g]);
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        nchk++;
        if (got != exp) begin
            nerr++;
            $display("FAIL %s got %0d exp %0d (t=%0t)", tag, got, exp, $time);
        end
    endtask

    // Every-cycle comparison of pins and update pulse against the model
    always @(negedge clk) begin
        #1;
        if (chk_on) begin
            chk("R1 update", update_o, m_upd);
            for (int g = 0; g < NCH; g++) begin
                if (!chan_en_i[g]) chk("R4 disabled pin", ch_o[g], 0);
                else if (g == 1 && m_flag) chk("R5 cleared pin", ch_o[g], pol_i[g]);
                else chk("R3 pwm pin", ch_o[g], exp_pin(g));
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    task automatic wait_cnt(input int v);
        int n = 0;
        while (m_cnt != v && n < 4000) begin @(negedge clk); n++; end
    endtask

    logic [7:0] lfsr = 8'hA5;
    int n, ups;

    initial begin
        cv[0] = 850; cv[1] = 850; cv[2] = 25; cv[3] = 850;
        chan_en_i = 4'hF;
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk_on = 1;
        #2;
        // R1 reset state
        chk("R1 reset update", update_o, 0);
        chk("R1 reset ch0", ch_o[0], 1);

        // R10: idle without start
        ups = 0;
        repeat (20) begin @(negedge clk); #2; ups += update_o; end
        chk("R10 idle no update", ups, 0);
        chk("R10 idle count held", m_cnt, 0);

        // R2 / R10: start, first period is the reset default
        period_i = 9;
        n = 0; start_i = 1;
        do begin @(negedge clk); start_i = 0; #2; n++; end while (!update_o && n < 5000);
        chk("R2 first update after default period", n, 1702);
        n = 0;
        do begin @(negedge clk); #2; n++; end while (!update_o && n < 100);
        chk("R2 preloaded period 9", n, 10);
        chk("R1 update spacing", n, 10);

        // Sweep: compare values, modes, polarities, enables, random comparator
        for (int bm = 0; bm < 2; bm++) begin
            for (int c = 0; c < 11; c++) begin
                for (int m = 0; m < 2; m++) begin
                    for (int p = 0; p < 2; p++) begin
                        @(negedge clk);
                        cv[0] = 16'((c * 3) % 11); cv[1] = 16'(c);
                        cv[2] = bm ? 16'd7 : 16'd3; cv[3] = 16'(10 - c);
                        mode_i = {1'(m), 1'(bm), 1'(m), 1'(~m)};
                        pol_i  = {1'(p), 1'b0, 1'(p), 1'(~p)};
                        chan_en_i = {1'(p ^ m), 1'b1, 1'b1, 1'(c != 5)};
                        for (int k = 0; k < 11; k++) begin
                            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                            cmp_in_i = (lfsr[2:0] == 3'd0);
                            @(negedge clk);
                        end
                        cmp_in_i = 0;
                    end
                end
            end
        end

        // Directed: ch1 mode 0 compare 8, blank channel mode 0 compare 3
        @(negedge clk);
        cv[1] = 8; cv[2] = 3; mode_i = 4'b0000; pol_i = 4'b0000; chan_en_i = 4'hF;
        wait_cnt(0);
        // R6: request inside blanking is ignored
        wait_cnt(1); cmp_in_i = 1;
        @(negedge clk); cmp_in_i = 0; #2;
        chk("R6 blanked request ignored", ch_o[1], 1);
        // R5: request outside blanking clears until update
        wait_cnt(5); cmp_in_i = 1;
        @(negedge clk); cmp_in_i = 0; #2;
        chk("R5 cleared pin low", ch_o[1], 0);
        pol_i[1] = 1; #1;
        chk("R5 cleared pin follows polarity", ch_o[1], 1);
        pol_i[1] = 0;
        wait_cnt(0); #2;
        chk("R5 released at update", ch_o[1], 1);

        // R7: request on the same edge as the update
        wait_cnt(9); cmp_in_i = 1;
        @(negedge clk); cmp_in_i = 0; #2;
        chk("R7 update wins", update_o, 1);
        chk("R7 pin not cleared", ch_o[1], 1);

        // R8: one-pulse stop
        one_pulse_i = 1;
        n = 0;
        do begin @(negedge clk); #2; n++; end while (!update_o && n < 100);
        ups = 0;
        repeat (25) begin @(negedge clk); #2; ups += update_o; end
        chk("R8 stopped no update", ups, 0);
        chk("R8 stopped at zero", m_cnt, 0);
        chk("R8 pin at count 0", ch_o[1], 1);

        // R9: trigger restart while stopped, no update, then a full period
        slave_en_i = 1; trig_i = 1;
        @(negedge clk); #2;
        chk("R9 no update on trigger", update_o, 0);
        trig_i = 0;
        n = 1;
        do begin @(negedge clk); #2; n++; end while (!update_o && n < 100);
        chk("R9 full period after trigger", n, 11);
        // R9: trigger mid-period keeps clear flag
        one_pulse_i = 0;
        start_i = 1; @(negedge clk); start_i = 0;
        wait_cnt(5); cmp_in_i = 1;
        @(negedge clk); cmp_in_i = 0; trig_i = 1;
        @(negedge clk); trig_i = 0; #2;
        chk("R9 trigger reset count", m_cnt, 0);
        chk("R9 flag kept over trigger", ch_o[1], 0);
        repeat (30) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule